// File: doc/BRIEF.md
# Fetch-Stage Branch Target Cache

This block sits next to the instruction fetch address generator. It remembers the address of each simple direct branch that the execute stage has resolved, together with where that branch went. While the front end fetches sequentially, it looks ahead in that store. When the address now being fetched holds a branch that was last seen taken, the block asks the fetch unit to jump to the remembered target on the next cycle. It also raises a marker one cycle later, alongside the returned instruction, so that decode does not apply its own static guess to that instruction.

The store is direct-mapped. An index taken from the instruction-word bits of the address selects an entry holding a tag (the address bits above the index), a target and a valid flag. Every resolved simple branch writes its entry. A taken outcome sets the valid flag and a not-taken outcome clears it. So that the compare stays short, each read is issued for the current fetch address plus 8 and carried through two register stages. As a result the first two fetches after any non-sequential fetch cannot predict. A build parameter can remove the cache entirely, and the outputs are then tied inactive.

Top module: `fetch_btc`

## Requirements
- R1: On a prediction, `pred_target` equals the target last written for that entry, with its two low bits zero.
- R2: The entry index is address bits [IDX_W+1:2] and the tag is bits [ADDR_W-1:IDX_W+2]. A fetch whose tag differs from the stored tag never predicts, even when the index matches.
- R3: An update with `upd_taken`=1 makes its entry valid and an update with `upd_taken`=0 makes it invalid. In both cases the tag and target are rewritten.
- R4: `pred_redirect` is asserted in the cycle that fetches a branch address held in a valid entry with a matching tag, and only when `fetch_seq`=1 in that cycle.
- R5: A fetch can predict only if `fetch_seq` was 1 in the previous cycle as well. The first and second fetches after a non-sequential fetch never predict, and the third can.
- R6: A read of an index in the same cycle as a write to that index returns the old contents. A fetch therefore sees an update only if the update was presented at least three cycles earlier.
- R7: `late_redirect`=1 suppresses `pred_redirect` in the same cycle.
- R8: `pred_taken_mark` is 1 in exactly those cycles that follow a cycle with `pred_redirect`=1.
- R9: Reset (synchronous, `rst_n`=0) clears every valid flag in one cycle. Outputs are 0 during reset, and no entry trained before reset predicts after it.
- R10: With `BTC_EN`=0 the block never asserts `pred_redirect` or `pred_taken_mark`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_nia | input | ADDR_W | Address fetched this cycle |
| fetch_seq | input | 1 | This fetch is the previous address plus 4 |
| late_redirect | input | 1 | A later stage redirects fetch this cycle |
| upd_en | input | 1 | Resolved simple branch update valid |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_target | input | ADDR_W | Target of the resolved branch |
| upd_taken | input | 1 | Resolved branch was taken |
| pred_redirect | output | 1 | Fetch the predicted target next |
| pred_target | output | ADDR_W | Predicted target address |
| pred_taken_mark | output | 1 | Instruction returned this cycle was predicted taken |

## Verification
The bench sweeps the position of a trained branch across every entry, measured from a redirect. A design that reads with the wrong lookahead, or that does not invalidate the pipeline, would predict on the first or second fetch, or never on the third. It varies the distance between an update and the fetch it affects around three cycles. This catches a store that forwards same-cycle writes, and one that delays them an extra cycle. It fetches aliasing addresses with the same index but a different tag, and it raises a late redirect on a hit cycle. A tag-less compare would predict falsely on the aliases, and missing priority logic would leak a redirect on the hit cycle. A long pseudo-random run mixes taken and not-taken updates, aliases and redirects against an arithmetic model of the entries.

// File: rtl/btc_pkg.sv
// Package: shared constants for the fetch-stage branch target cache.
// Assumes 4-byte instructions, so the two low address bits are never stored.
package btc_pkg;
    localparam int unsigned INSN_LSB        = 2;
    localparam int unsigned LOOKAHEAD_BYTES = 8;
endpackage

// File: rtl/btc_store.sv
// Module: btc_store
// Direct-mapped entry storage. Tag and target sit in plain arrays without
// reset. Valid flags are a separate flop vector so that reset clears them in
// one cycle. The read is synchronous; a same-cycle write is not forwarded.
module btc_store #(
    parameter int unsigned IDX_W = 10,
    parameter int unsigned TAG_W = 52,
    parameter int unsigned TGT_W = 62
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag,
    output logic [TGT_W-1:0] rd_tgt
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic [TGT_W-1:0] tgt_mem [DEPTH];
    logic [DEPTH-1:0] vld_q;

    // Write tag and target of every resolved branch.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
            tgt_mem[wr_idx] <= wr_tgt;
        end
    end

    // Keep valid flags: cleared on reset, set or cleared by an update.
    always_ff @(posedge clk) begin
        if (!rst_n)     vld_q <= '0;
        else if (wr_en) vld_q[wr_idx] <= wr_valid;
    end

    // Register the lookahead read; it returns pre-write contents.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_vld <= 1'b0;
        else        rd_vld <= vld_q[rd_idx];
        rd_tag <= tag_mem[rd_idx];
        rd_tgt <= tgt_mem[rd_idx];
    end

    // R3
    property taken_sets_p;
        @(posedge clk) disable iff (!rst_n) (wr_en && wr_valid) |=> vld_q[$past(wr_idx)];
    endproperty
    taken_sets_chk: assert property (taken_sets_p);

    // R3
    property not_taken_clears_p;
        @(posedge clk) disable iff (!rst_n) (wr_en && !wr_valid) |=> !vld_q[$past(wr_idx)];
    endproperty
    not_taken_clears_chk: assert property (not_taken_clears_p);

    // R9
    property reset_clears_p;
        @(posedge clk) !rst_n |=> (vld_q == '0);
    endproperty
    reset_clears_chk: assert property (reset_clears_p);
endmodule

// File: rtl/btc_lookup.sv
// Module: btc_lookup
// Issues the read for fetch address + 8 and carries the result through two
// stages. It then compares the result with the address being fetched. A stage
// survives only across sequential fetches, so the first two fetches after a
// jump cannot hit. Assumes the store output is registered, matching stage 1.
module btc_lookup
    import btc_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_nia,
    input  logic              fetch_seq,
    input  logic              late_redirect,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_vld,
    input  logic [ADDR_W-IDX_W-INSN_LSB-1:0] rd_tag,
    input  logic [ADDR_W-INSN_LSB-1:0]       rd_tgt,
    output logic              hit,
    output logic [ADDR_W-1:0] hit_target,
    output logic              hit_mark
);
    localparam int unsigned TAG_W  = ADDR_W - IDX_W - INSN_LSB;
    localparam int unsigned TGT_W  = ADDR_W - INSN_LSB;
    localparam int unsigned TAG_LO = IDX_W + INSN_LSB;

    logic [ADDR_W-1:0] ahead_addr;
    logic              s1_live;
    logic [ADDR_W-1:0] s1_addr;
    logic              s2_live;
    logic [ADDR_W-1:0] s2_addr;
    logic              s2_vld;
    logic [TAG_W-1:0]  s2_tag;
    logic [TGT_W-1:0]  s2_tgt;

    // Form the lookahead address and its index.
    always_comb begin
        ahead_addr = fetch_nia + ADDR_W'(LOOKAHEAD_BYTES);
        rd_idx     = ahead_addr[TAG_LO-1:INSN_LSB];
    end

    // Stage 1: remember which address the read was issued for.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_live <= 1'b0;
            s1_addr <= '0;
        end else begin
            s1_live <= 1'b1;
            s1_addr <= ahead_addr;
        end
    end

    // Stage 2: hold entry and address; a non-sequential fetch kills it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_live <= 1'b0;
            s2_addr <= '0;
            s2_vld  <= 1'b0;
            s2_tag  <= '0;
            s2_tgt  <= '0;
        end else begin
            s2_live <= s1_live && fetch_seq;
            s2_addr <= s1_addr;
            s2_vld  <= rd_vld;
            s2_tag  <= rd_tag;
            s2_tgt  <= rd_tgt;
        end
    end

    // Decide the hit; a later-stage redirect wins over it.
    always_comb begin
        hit = s2_live && s2_vld && fetch_seq && !late_redirect
              && (s2_addr == fetch_nia)
              && (s2_tag == fetch_nia[ADDR_W-1:TAG_LO]);
        hit_target = {s2_tgt, {INSN_LSB{1'b0}}};
    end

    // Delay the hit by one cycle to tag the returned instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_mark <= 1'b0;
        else        hit_mark <= hit;
    end

    // R4
    property hit_needs_seq_p;
        @(posedge clk) disable iff (!rst_n) hit |-> fetch_seq;
    endproperty
    hit_needs_seq_chk: assert property (hit_needs_seq_p);

    // R5
    property hit_needs_prev_seq_p;
        @(posedge clk) disable iff (!rst_n) hit |-> $past(fetch_seq);
    endproperty
    hit_needs_prev_seq_chk: assert property (hit_needs_prev_seq_p);
endmodule

// File: rtl/fetch_btc.sv
// Module: fetch_btc (top)
// Fetch-stage branch target cache: predicts taken simple branches during
// sequential fetch. BTC_EN=0 removes the cache and ties the outputs low.
// Assumes 4-byte aligned instructions and that fetch follows pred_redirect.
module fetch_btc
    import btc_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned IDX_W  = 10,
    parameter bit          BTC_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_nia,
    input  logic              fetch_seq,
    input  logic              late_redirect,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              upd_taken,
    output logic              pred_redirect,
    output logic [ADDR_W-1:0] pred_target,
    output logic              pred_taken_mark
);
    localparam int unsigned TAG_LO = IDX_W + INSN_LSB;
    localparam int unsigned TAG_W  = ADDR_W - TAG_LO;
    localparam int unsigned TGT_W  = ADDR_W - INSN_LSB;

    generate
        if (BTC_EN) begin : g_cache
            logic [IDX_W-1:0] rd_idx;
            logic             rd_vld;
            logic [TAG_W-1:0] rd_tag;
            logic [TGT_W-1:0] rd_tgt;
            logic             unused_lsbs;

            // Low address bits are implied by instruction alignment.
            assign unused_lsbs = ^{upd_addr[INSN_LSB-1:0], upd_target[INSN_LSB-1:0]};

            btc_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_store (
                .clk      (clk),
                .rst_n    (rst_n),
                .rd_idx   (rd_idx),
                .wr_en    (upd_en),
                .wr_idx   (upd_addr[TAG_LO-1:INSN_LSB]),
                .wr_valid (upd_taken),
                .wr_tag   (upd_addr[ADDR_W-1:TAG_LO]),
                .wr_tgt   (upd_target[ADDR_W-1:INSN_LSB]),
                .rd_vld   (rd_vld),
                .rd_tag   (rd_tag),
                .rd_tgt   (rd_tgt)
            );

            btc_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lookup (
                .clk           (clk),
                .rst_n         (rst_n),
                .fetch_nia     (fetch_nia),
                .fetch_seq     (fetch_seq),
                .late_redirect (late_redirect),
                .rd_idx        (rd_idx),
                .rd_vld        (rd_vld),
                .rd_tag        (rd_tag),
                .rd_tgt        (rd_tgt),
                .hit           (pred_redirect),
                .hit_target    (pred_target),
                .hit_mark      (pred_taken_mark)
            );
        end else begin : g_none
            assign pred_redirect   = 1'b0;
            assign pred_target     = '0;
            assign pred_taken_mark = 1'b0;
        end
    endgenerate

    // R8
    property mark_follows_p;
        @(posedge clk) disable iff (!rst_n) pred_redirect |=> pred_taken_mark;
    endproperty
    mark_follows_chk: assert property (mark_follows_p);

    // R8
    property mark_has_cause_p;
        @(posedge clk) disable iff (!rst_n) pred_taken_mark |-> $past(pred_redirect);
    endproperty
    mark_has_cause_chk: assert property (mark_has_cause_p);

    // R7
    property late_wins_p;
        @(posedge clk) disable iff (!rst_n) late_redirect |-> !pred_redirect;
    endproperty
    late_wins_chk: assert property (late_wins_p);
endmodule

// File: tb/sim_fetch_btc.sv
`timescale 1ns/1ps
module sim_fetch_btc;
    localparam int AW = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] nia_i = '0;
    logic          seq_i = 1'b0;
    logic          lr_i = 1'b0;
    logic          ue_i = 1'b0;
    logic [AW-1:0] ua_i = '0;
    logic [AW-1:0] ut_i = '0;
    logic          utk_i = 1'b0;
    logic          pred_redirect, pred_taken_mark;
    logic [AW-1:0] pred_target;
    logic          d_redirect, d_mark;
    logic [AW-1:0] d_target;

    always #4 clk = ~clk;

    fetch_btc #(.ADDR_W(AW), .IDX_W(IW), .BTC_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_nia(nia_i), .fetch_seq(seq_i),
        .late_redirect(lr_i), .upd_en(ue_i), .upd_addr(ua_i), .upd_target(ut_i),
        .upd_taken(utk_i), .pred_redirect(pred_redirect), .pred_target(pred_target),
        .pred_taken_mark(pred_taken_mark));

    fetch_btc #(.ADDR_W(AW), .IDX_W(IW), .BTC_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .fetch_nia(nia_i), .fetch_seq(seq_i),
        .late_redirect(lr_i), .upd_en(ue_i), .upd_addr(ua_i), .upd_target(ut_i),
        .upd_taken(utk_i), .pred_redirect(d_redirect), .pred_target(d_target),
        .pred_taken_mark(d_mark));

    int checks = 0;
    int failures = 0;
    int hit_cnt = 0;
    bit finished = 0;

    // Reference model of the entries and the two lookahead stages.
    logic          m_v   [16];
    logic [9:0]    m_tag [16];
    logic [AW-1:0] m_tgt [16];
    logic s1_pv, s1_v, s2_pv, s2_v;
    logic [9:0] s1_tag, s2_tag;
    logic [AW-1:0] s1_tgt, s2_tgt, s1_addr, s2_addr;
    logic prev_hit, last_hit;
    logic [AW-1:0] last_tgt;
    logic [AW-1:0] cur;
    logic cur_seq;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
        s1_pv = 0; s2_pv = 0; s1_v = 0; s2_v = 0; prev_hit = 0; last_hit = 0;
    endtask

    task automatic cyc(input logic [AW-1:0] nia, input logic sq, input logic lr, input logic ue,
                       input logic [AW-1:0] ua, input logic [AW-1:0] ut, input logic tk);
        logic eh;
        logic [AW-1:0] la;
        @(negedge clk);
        nia_i = nia; seq_i = sq; lr_i = lr; ue_i = ue; ua_i = ua; ut_i = ut; utk_i = tk;
        #3;
        eh = s2_pv && sq && s2_v && (s2_addr == nia) && (s2_tag == nia[15:6]) && !lr;
        chk(pred_redirect === eh, "R4 R5 R6 R7 pred_redirect", pred_redirect, eh);
        if (eh) chk(pred_target === s2_tgt, "R1 pred_target", pred_target, s2_tgt);
        chk(pred_taken_mark === prev_hit, "R8 pred_taken_mark", pred_taken_mark, prev_hit);
        chk((d_redirect === 1'b0) && (d_mark === 1'b0), "R10 disabled outputs", {d_redirect, d_mark}, 0);
        if (pred_redirect) hit_cnt++;
        last_hit = eh;
        last_tgt = s2_tgt;
        la = nia + 16'd8;
        s2_pv = s1_pv & sq; s2_v = s1_v; s2_tag = s1_tag; s2_tgt = s1_tgt; s2_addr = s1_addr;
        s1_pv = 1'b1; s1_v = m_v[la[5:2]]; s1_tag = m_tag[la[5:2]];
        s1_tgt = m_tgt[la[5:2]]; s1_addr = la;
        prev_hit = eh;
        if (ue) begin
            m_v[ua[5:2]] = tk; m_tag[ua[5:2]] = ua[15:6]; m_tgt[ua[5:2]] = ut & 16'hFFFC;
        end
    endtask

    task automatic step(input logic lr, input logic [AW-1:0] ra, input logic ue,
                        input logic [AW-1:0] ua, input logic [AW-1:0] ut, input logic tk);
        cyc(cur, cur_seq, lr, ue, ua, ut, tk);
        if (lr) begin cur = ra; cur_seq = 0; end
        else if (last_hit) begin cur = last_tgt; cur_seq = 0; end
        else begin cur = cur + 16'd4; cur_seq = 1; end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, '0, '0, 0);
    endtask

    task automatic hop(input logic [AW-1:0] a);
        cur = a; cur_seq = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            ue_i = 0; lr_i = 0; seq_i = 0;
            #3;
            chk((pred_redirect === 1'b0) && (pred_taken_mark === 1'b0), "R9 outputs in reset",
                {pred_redirect, pred_taken_mark}, 0);
        end
        model_clear();
        @(negedge clk);
        rst_n = 1;
        hop(16'h8000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();
        idle(4);

        // Branch slot sweep from a redirect: R5 (hit only from third fetch), R1
        for (int b = 0; b < 16; b++) begin
            hop(16'h8000);
            step(0, '0, 1, 16'h0100 + 16'(4 * b), 16'h2000 + 16'(16 * b), 1);
            idle(3);
            hop(16'h0100);
            hit_cnt = 0;
            idle(18);
            chk(hit_cnt == ((b >= 2) ? 1 : 0), "R5 hits from slot", hit_cnt, (b >= 2) ? 1 : 0);
            // Alias with different tag, same index: R2
            hop(16'h0500 + 16'(4 * b) - 16'd8);
            hit_cnt = 0;
            idle(4);
            chk(hit_cnt == 0, "R2 alias tag", hit_cnt, 0);
            // Not-taken update invalidates: R3
            hop(16'h8000);
            step(0, '0, 1, 16'h0100 + 16'(4 * b), 16'h2000, 0);
            idle(3);
            hop(16'h0100);
            hit_cnt = 0;
            idle(18);
            chk(hit_cnt == 0, "R3 not-taken clears", hit_cnt, 0);
        end

        // Update-to-fetch distance: R6
        for (int d = 1; d <= 5; d++) begin
            hop(16'h8000);
            step(0, '0, 1, 16'h0300, 16'h0000, 0);
            idle(3);
            hop(16'h0300 - 16'd24);
            hit_cnt = 0;
            for (int i = 0; i < 10; i++) begin
                if (i == 6 - d) step(0, '0, 1, 16'h0300, 16'h3000, 1);
                else            step(0, '0, 0, '0, '0, 0);
            end
            chk(hit_cnt == ((d >= 3) ? 1 : 0), "R6 update distance", hit_cnt, (d >= 3) ? 1 : 0);
        end

        // Late redirect on the hit cycle: R7
        hop(16'h8000);
        step(0, '0, 1, 16'h0400, 16'h4400, 1);
        idle(3);
        hop(16'h0400 - 16'd16);
        hit_cnt = 0;
        for (int i = 0; i < 6; i++) step(i == 4, 16'h0600, 0, '0, '0, 0);
        chk(hit_cnt == 0, "R7 late redirect wins", hit_cnt, 0);
        hop(16'h0400 - 16'd16);
        hit_cnt = 0;
        idle(6);
        chk(hit_cnt == 1, "R7 same path without redirect", hit_cnt, 1);

        // Reset wipes trained entries: R9
        do_reset();
        hop(16'h0400 - 16'd16);
        hit_cnt = 0;
        idle(8);
        chk(hit_cnt == 0, "R9 no hit after reset", hit_cnt, 0);

        // Pseudo-random mix of updates, aliases and redirects.
        hop(16'h0100);
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (cur < 16'h0100 || cur > 16'h01FC) hop(16'h0100 + {8'h0, lfsr[7:2], 2'b00});
            step(lfsr[13:10] == 4'h0, 16'h0100 + {8'h0, lfsr[5:0], 2'b00},
                 lfsr[0] & lfsr[1], 16'h0100 + {8'h0, lfsr[8:3], 2'b00},
                 16'h0100 + {8'h0, lfsr[14:9], 2'b00}, lfsr[9] | lfsr[15]);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule